// File: doc/BRIEF.md
# IRIG-B Time Code Decoder

This block turns a pulse-width-coded IRIG-B serial time code into a stream of classified symbols and a time-of-day value. The serial input is a single-bit level that has already been synchronized to the block clock. A free-running prescaler divides the clock into measurement units of 0.1 ms. The high time of every pulse is counted in these units and then sorted into a binary zero, a binary one or a position marker. A width that fits none of these classes is reported as an invalid symbol.

A frame-alignment stage searches for two position markers in a row. The second marker of the pair is taken as symbol 0 of a new frame. From then on, the stage checks that markers appear only where the format places them. When a frame completes without any fault, the stage latches the BCD seconds, minutes, hours and day-of-year fields. It raises a one-cycle on-time strobe at the leading edge of each whole-second reference marker, and downstream logic uses that strobe to clear its sample counters. Status outputs report a confirmed frame lock and a fault condition.

The default parameters suit a 100 MHz clock (10,000 clocks per 0.1 ms unit). All widths and tolerances are given in units.

Top module: `irig_b_decoder`

## Requirements
- R1: A pulse whose high time, in 0.1 ms units, falls within ±5 units of a nominal width is classified as follows: 20 gives code 0 (binary zero), 50 gives code 1 (binary one), 80 gives code 2 (position marker). Any other width gives code 3 (invalid) and sets `frame_err`.
- R2: Every falling edge of `irig_in` produces a one-cycle `sym_valid` pulse carrying `sym_kind`. The pulse appears in the clock cycle after the first low sample.
- R3: While unaligned, the block locks when a position marker directly follows another position marker. The second marker becomes symbol index 0, and the first frame built from that point is decoded.
- R4: `on_time` is a one-cycle pulse, asserted in the cycle after the first high sample of a reference marker. It is issued only when the preceding frame was decoded completely while locked, and never in any other case.
- R5: While locked, a marker is required at index 0 and at every index whose units digit is 9 (9, 19, …, 99). A marker at any other index, or a non-marker at one of these indices, sets `frame_err` and drops lock.
- R6: After the marker at index 99 of a fault-free locked frame, the fields are latched with the least significant bit first. Seconds take units from indices 1–4 and tens from 6–8. Minutes take units from 10–13 and tens from 15–17. Hours take units from 20–23 and tens from 25–26. Day-of-year takes units from 30–33, tens from 35–38 and hundreds from 40–41. The fields do not change at any other time.
- R7: `frame_valid` rises when the second consecutive fault-free frame completes. Any detected fault clears it.
- R8: `frame_err` stays set after a fault until the next fault-free frame completes.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irig_in | input | 1 | Synchronized serial time-code level |
| sym_valid | output | 1 | One-cycle pulse per classified symbol |
| sym_kind | output | 2 | Symbol code: 0 zero, 1 one, 2 marker, 3 invalid |
| on_time | output | 1 | One-cycle strobe at the whole-second reference edge |
| sec_bcd | output | 7 | Seconds in BCD: tens in [6:4], units in [3:0] |
| min_bcd | output | 7 | Minutes in BCD: tens in [6:4], units in [3:0] |
| hour_bcd | output | 6 | Hours in BCD: tens in [5:4], units in [3:0] |
| day_bcd | output | 10 | Day-of-year in BCD: hundreds in [9:8], tens in [7:4], units in [3:0] |
| frame_valid | output | 1 | Two or more consecutive fault-free frames decoded |
| frame_err | output | 1 | A fault has occurred since the last fault-free frame |

## Verification
The properties assume that `irig_in` is already synchronous to the clock. They also assume that every high and low interval lasts at least two clocks, so that a symbol event and the edge behind it can be related through one or two cycles of history. The stimulus drives the input only at falling clock edges, and every symbol fills a full 100-unit period. Width jitter is drawn from inside the tolerance band, and the frames that inject faults exceed it only on purpose. Frames run back to back, so the only marker pair the block can lock on is the true index-99 and index-0 pair. The injected faults are placed where they cannot create a false marker pair: a marker at index 3, a missing marker at index 49, and an out-of-band width at index 35.

// File: rtl/irig_pkg.sv
package irig_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_MARK = 2'd2,
        SYM_BAD  = 2'd3
    } sym_e;

    // symbol index kept as two decimal digits, 0..9 each
    localparam logic [3:0] DIGIT_LAST = 4'd9;
    // number of leading symbols holding the decoded time fields
    localparam int DATA_SPAN = 42;

endpackage

// File: rtl/irig_tick_gen.sv
module irig_tick_gen #(
    parameter int CLKS_PER_UNIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (CLKS_PER_UNIT <= 1) begin : g_direct
            logic unused_in;
            assign unused_in = clk ^ rst_n;
            assign tick      = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(CLKS_PER_UNIT);
            localparam logic [DW-1:0] TOP = DW'(CLKS_PER_UNIT - 1);

            typedef struct packed {
                logic [DW-1:0] cnt;
                logic          tick;
            } div_t;

            div_t div_d, div_q;

            always_comb begin
                div_d      = div_q;
                div_d.tick = 1'b0;
                if (div_q.cnt == TOP) begin
                    div_d.cnt  = '0;
                    div_d.tick = 1'b1;
                end else begin
                    div_d.cnt = div_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign tick = div_q.tick;
        end
    endgenerate

endmodule

// File: rtl/irig_pulse_meter.sv
module irig_pulse_meter
    import irig_pkg::*;
#(
    parameter int W_ZERO = 20,
    parameter int W_ONE  = 50,
    parameter int W_MARK = 80,
    parameter int W_TOL  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       lvl,
    output logic       rise,
    output logic       sym_vld,
    output logic [1:0] sym_kind
);

    localparam int CNT_W = $clog2(W_MARK + W_TOL + 2) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        sym_e             kind;
    } meter_t;

    meter_t mtr_d, mtr_q;
    logic   fall;

    function automatic logic in_win(input logic [CNT_W-1:0] w, input int nom);
        return (int'(w) >= nom - W_TOL) && (int'(w) <= nom + W_TOL);
    endfunction

    function automatic sym_e classify(input logic [CNT_W-1:0] w);
        if (in_win(w, W_ZERO))      return SYM_ZERO;
        else if (in_win(w, W_ONE))  return SYM_ONE;
        else if (in_win(w, W_MARK)) return SYM_MARK;
        else                        return SYM_BAD;
    endfunction

    always_comb begin
        mtr_d     = mtr_q;
        mtr_d.lvl = lvl;
        mtr_d.vld = 1'b0;
        rise      = lvl & ~mtr_q.lvl;
        fall      = ~lvl & mtr_q.lvl;
        if (rise) begin
            mtr_d.cnt = CNT_W'(1);
        end else if (lvl && tick && (mtr_q.cnt != CNT_MAX)) begin
            mtr_d.cnt = mtr_q.cnt + 1'b1;
        end
        if (fall) begin
            mtr_d.vld  = 1'b1;
            mtr_d.kind = classify(mtr_q.cnt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mtr_q <= '{lvl: 1'b0, cnt: '0, vld: 1'b0, kind: SYM_ZERO};
        else        mtr_q <= mtr_d;
    end

    assign sym_vld  = mtr_q.vld;
    assign sym_kind = mtr_q.kind;

endmodule

// File: rtl/irig_frame_sync.sv
module irig_frame_sync
    import irig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       sym_vld,
    input  logic [1:0] sym_kind,
    output logic       on_time,
    output logic [6:0] sec_bcd,
    output logic [6:0] min_bcd,
    output logic [5:0] hour_bcd,
    output logic [9:0] day_bcd,
    output logic       frame_valid,
    output logic       frame_err
);

    typedef struct packed {
        logic                 locked;
        logic                 prev_mark;
        logic [3:0]           tens;
        logic [3:0]           ones;
        logic [DATA_SPAN-1:0] bits;
        logic [1:0]           good;
        logic                 valid;
        logic                 err;
        logic                 strobe;
        logic [6:0]           sec;
        logic [6:0]           mins;
        logic [5:0]           hour;
        logic [9:0]           day;
    } sync_t;

    sync_t sync_d, sync_q;

    logic                 is_mark;
    logic                 is_bad;
    logic [3:0]           nx_tens;
    logic [3:0]           nx_ones;
    logic                 want_mark;
    logic                 in_span;
    logic                 at_end;
    logic                 last_idx;
    logic [DATA_SPAN-1:0] shifted;

    always_comb begin
        is_mark  = (sym_kind == SYM_MARK);
        is_bad   = (sym_kind == SYM_BAD);
        last_idx = (sync_q.tens == DIGIT_LAST) && (sync_q.ones == DIGIT_LAST);

        if (sync_q.ones == DIGIT_LAST) begin
            nx_ones = 4'd0;
            nx_tens = (sync_q.tens == DIGIT_LAST) ? 4'd0 : sync_q.tens + 4'd1;
        end else begin
            nx_ones = sync_q.ones + 4'd1;
            nx_tens = sync_q.tens;
        end
        want_mark = (nx_ones == DIGIT_LAST) || ((nx_ones == 4'd0) && (nx_tens == 4'd0));
        in_span   = (int'(nx_tens) * 10 + int'(nx_ones)) < DATA_SPAN;
        at_end    = (nx_tens == DIGIT_LAST) && (nx_ones == DIGIT_LAST);
        shifted   = {(sym_kind == SYM_ONE), sync_q.bits[DATA_SPAN-1:1]};

        sync_d        = sync_q;
        sync_d.strobe = rise && sync_q.locked && last_idx;

        if (sym_vld) begin
            if (!sync_q.locked) begin
                if (is_bad) begin
                    sync_d.err       = 1'b1;
                    sync_d.prev_mark = 1'b0;
                end else if (is_mark && sync_q.prev_mark) begin
                    sync_d.locked    = 1'b1;
                    sync_d.prev_mark = 1'b0;
                    sync_d.tens      = 4'd0;
                    sync_d.ones      = 4'd0;
                    sync_d.bits      = shifted;
                end else begin
                    sync_d.prev_mark = is_mark;
                end
            end else if (is_bad || (is_mark != want_mark)) begin
                sync_d.locked    = 1'b0;
                sync_d.prev_mark = is_mark;
                sync_d.err       = 1'b1;
                sync_d.good      = 2'd0;
                sync_d.valid     = 1'b0;
            end else begin
                sync_d.tens = nx_tens;
                sync_d.ones = nx_ones;
                if (in_span) begin
                    sync_d.bits = shifted;
                end
                if (at_end) begin
                    sync_d.sec   = {sync_q.bits[8:6], sync_q.bits[4:1]};
                    sync_d.mins  = {sync_q.bits[17:15], sync_q.bits[13:10]};
                    sync_d.hour  = {sync_q.bits[26:25], sync_q.bits[23:20]};
                    sync_d.day   = {sync_q.bits[41:40], sync_q.bits[38:35], sync_q.bits[33:30]};
                    sync_d.good  = (sync_q.good == 2'd2) ? 2'd2 : sync_q.good + 2'd1;
                    sync_d.valid = (sync_q.good != 2'd0);
                    sync_d.err   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign on_time     = sync_q.strobe;
    assign sec_bcd     = sync_q.sec;
    assign min_bcd     = sync_q.mins;
    assign hour_bcd    = sync_q.hour;
    assign day_bcd     = sync_q.day;
    assign frame_valid = sync_q.valid;
    assign frame_err   = sync_q.err;

endmodule

// File: rtl/irig_b_decoder.sv
module irig_b_decoder #(
    parameter int CLKS_PER_UNIT = 10000,
    parameter int W_ZERO        = 20,
    parameter int W_ONE         = 50,
    parameter int W_MARK        = 80,
    parameter int W_TOL         = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irig_in,
    output logic       sym_valid,
    output logic [1:0] sym_kind,
    output logic       on_time,
    output logic [6:0] sec_bcd,
    output logic [6:0] min_bcd,
    output logic [5:0] hour_bcd,
    output logic [9:0] day_bcd,
    output logic       frame_valid,
    output logic       frame_err
);

    logic unit_tick;
    logic lvl_rise;

    irig_tick_gen #(
        .CLKS_PER_UNIT(CLKS_PER_UNIT)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (unit_tick)
    );

    irig_pulse_meter #(
        .W_ZERO(W_ZERO),
        .W_ONE (W_ONE),
        .W_MARK(W_MARK),
        .W_TOL (W_TOL)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (unit_tick),
        .lvl     (irig_in),
        .rise    (lvl_rise),
        .sym_vld (sym_valid),
        .sym_kind(sym_kind)
    );

    irig_frame_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (lvl_rise),
        .sym_vld    (sym_valid),
        .sym_kind   (sym_kind),
        .on_time    (on_time),
        .sec_bcd    (sec_bcd),
        .min_bcd    (min_bcd),
        .hour_bcd   (hour_bcd),
        .day_bcd    (day_bcd),
        .frame_valid(frame_valid),
        .frame_err  (frame_err)
    );

endmodule

// File: rtl/irig_b_decoder_chk.sv
module irig_b_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irig_in,
    input logic       sym_valid,
    input logic [1:0] sym_kind,
    input logic       on_time,
    input logic [6:0] sec_bcd,
    input logic [6:0] min_bcd,
    input logic [5:0] hour_bcd,
    input logic [9:0] day_bcd,
    input logic       frame_valid,
    input logic       frame_err
);

    AST_BAD_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 2'd3) |=> frame_err); // R1

    AST_SYM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid); // R2

    AST_SYM_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (!$past(irig_in) && $past(irig_in, 2))); // R2

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        on_time |=> !on_time); // R4

    AST_STROBE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        on_time |-> ($past(irig_in) && !$past(irig_in, 2))); // R4

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sec_bcd, min_bcd, hour_bcd, day_bcd}) |->
            ($past(sym_valid) && $past(sym_kind) == 2'd2)); // R6

    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_bcd[3:0] <= 4'd9) && (min_bcd[3:0] <= 4'd9) && (hour_bcd[3:0] <= 4'd9)); // R6

    AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> ($past(sym_valid) && $past(sym_kind) == 2'd2)); // R7

    AST_VALID_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> !frame_err); // R7

    AST_ERR_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err) |-> ($past(sym_valid) && $past(sym_kind) == 2'd2)); // R8

endmodule

bind irig_b_decoder irig_b_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irig_in    (irig_in),
    .sym_valid  (sym_valid),
    .sym_kind   (sym_kind),
    .on_time    (on_time),
    .sec_bcd    (sec_bcd),
    .min_bcd    (min_bcd),
    .hour_bcd   (hour_bcd),
    .day_bcd    (day_bcd),
    .frame_valid(frame_valid),
    .frame_err  (frame_err)
);

// File: tb/irig_b_decoder_tb.sv
module irig_b_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irig_in = 1'b0;
    logic       sym_valid;
    logic [1:0] sym_kind;
    logic       on_time;
    logic [6:0] sec_bcd;
    logic [6:0] min_bcd;
    logic [5:0] hour_bcd;
    logic [9:0] day_bcd;
    logic       frame_valid;
    logic       frame_err;

    always #2 clk = ~clk;

    irig_b_decoder #(.CLKS_PER_UNIT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .irig_in(irig_in),
        .sym_valid(sym_valid), .sym_kind(sym_kind), .on_time(on_time),
        .sec_bcd(sec_bcd), .min_bcd(min_bcd), .hour_bcd(hour_bcd), .day_bcd(day_bcd),
        .frame_valid(frame_valid), .frame_err(frame_err)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int strobe_cnt = 0;

    // model state
    bit first_frame = 1;
    bit prev_good   = 0;
    int m_good      = 0;
    bit m_err       = 0;
    int m_sec = 0, m_min = 0, m_hour = 0, m_day = 0;

    int syms [100];

    always @(negedge clk) if (on_time) strobe_cnt++;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int bcd2(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int bcd3(input int v);
        return ((v / 100) << 8) | (((v / 10) % 10) << 4) | (v % 10);
    endfunction

    task automatic place(input int start, input int val, input int n);
        for (int i = 0; i < n; i++) syms[start + i] = (val >> i) & 1;
    endtask

    task automatic build(input int s, input int m, input int h, input int d);
        for (int i = 0; i < 100; i++) syms[i] = ((i % 10) == 9 || i == 0) ? 2 : 0;
        place(1,  bcd2(s) & 15, 4);  place(6,  bcd2(s) >> 4, 3);
        place(10, bcd2(m) & 15, 4);  place(15, bcd2(m) >> 4, 3);
        place(20, bcd2(h) & 15, 4);  place(25, bcd2(h) >> 4, 2);
        place(30, bcd3(d) & 15, 4);  place(35, (bcd3(d) >> 4) & 15, 4);
        place(40, bcd3(d) >> 8, 2);
    endtask

    // one 100-unit symbol period; raise at a negedge, fall w cycles later
    task automatic send_sym(input int w, input int exp_kind, input bit is_ref, input bit exp_strobe);
        @(negedge clk);
        irig_in = 1'b1;
        @(negedge clk);
        if (is_ref) chk(on_time == exp_strobe, "R4", "on_time at reference edge", on_time, exp_strobe);
        repeat (w - 1) @(negedge clk);
        irig_in = 1'b0;
        @(negedge clk);
        chk(sym_valid == 1'b1 && sym_kind == exp_kind[1:0], (exp_kind == 3) ? "R1" : "R2",
            "symbol code", sym_valid ? int'(sym_kind) : -1, exp_kind);
        repeat (98 - w) @(negedge clk);
    endtask

    // fault: 0 none, 1 out-of-band width at 35, 2 marker at 3, 3 missing marker at 49, 4 edge widths
    task automatic send_frame(input int s, input int m, input int h, input int d, input int fault);
        int  w;
        int  nom;
        int  ek;
        int  s0;
        bit  good;
        bit  counted;
        bit  exp_strobe;
        build(s, m, h, d);
        if (fault == 2) syms[3] = 2;
        if (fault == 3) syms[49] = 0;
        exp_strobe = prev_good;
        s0 = strobe_cnt;
        for (int i = 0; i < 100; i++) begin
            nom = (syms[i] == 0) ? 20 : (syms[i] == 1) ? 50 : 80;
            if (fault == 4) w = nom + (((i % 2) == 0) ? -5 : 5);
            else            w = nom + $urandom_range(8) - 4;
            ek = syms[i];
            if (fault == 1 && i == 35) begin
                w  = 26;
                ek = 3;
            end
            send_sym(w, ek, i == 0, exp_strobe);
        end
        good    = (fault == 0 || fault == 4);
        counted = !first_frame;
        if (counted && good) begin
            m_good = (m_good >= 2) ? 2 : m_good + 1;
            m_err  = 0;
            m_sec = bcd2(s); m_min = bcd2(m); m_hour = bcd2(h); m_day = bcd3(d);
        end else if (!good) begin
            m_good = 0;
            m_err  = 1;
        end
        chk(frame_valid == (m_good >= 2), "R7", "frame_valid", frame_valid, m_good >= 2);
        chk(frame_err == m_err, (fault == 2 || fault == 3) ? "R5" : "R8", "frame_err", frame_err, m_err);
        chk(strobe_cnt - s0 == int'(exp_strobe), "R4", "strobes in frame", strobe_cnt - s0, exp_strobe);
        chk(sec_bcd == m_sec[6:0] && min_bcd == m_min[6:0], (counted && good && m_good == 1) ? "R3" : "R6",
            "sec/min", {sec_bcd, min_bcd}, {m_sec[6:0], m_min[6:0]});
        chk(hour_bcd == m_hour[5:0] && day_bcd == m_day[9:0], "R6", "hour/day",
            {hour_bcd, day_bcd}, {m_hour[5:0], m_day[9:0]});
        prev_good   = counted && good;
        first_frame = 0;
    endtask

    task automatic rnd_frame(input int fault);
        send_frame($urandom_range(59), $urandom_range(59), $urandom_range(23),
                   1 + $urandom_range(365), fault);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sym_valid == 0 && on_time == 0 && frame_valid == 0 && frame_err == 0, "R9",
            "status after reset", {sym_valid, on_time, frame_valid, frame_err}, 0);
        chk(sec_bcd == 0 && min_bcd == 0 && hour_bcd == 0 && day_bcd == 0, "R9",
            "fields after reset", {sec_bcd, min_bcd, hour_bcd, day_bcd}, 0);
        repeat (20) @(negedge clk);

        send_frame(59, 59, 23, 366, 0);
        rnd_frame(0);
        send_frame(0, 0, 0, 1, 0);
        rnd_frame(4);
        rnd_frame(0);
        rnd_frame(1);
        rnd_frame(0);
        rnd_frame(0);
        rnd_frame(2);
        rnd_frame(0);
        rnd_frame(3);
        send_frame(45, 37, 19, 299, 0);
        rnd_frame(0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule